// File: doc/BRIEF.md
# Configurable Multilevel Pipeline Register

The block holds four byte-wide storage stages, all fed from one shared data input and updated on the rising clock edge. The stages form two pairs, A (A1, A2) and B (B1, B2). A 2-bit operation code chooses among three behaviours:

- chain all four stages into one four-deep shift line;
- load the first level of one pair, so the two pairs act as independent two-deep stacks;
- hold everything.

Any one of the four stages can be routed to the output at any time through a combinational select. An active-low output enable puts the output into high impedance.

The build-time parameter `PUSH_DOWN` sets how a pair load behaves. With `PUSH_DOWN=1`, the first level's old value moves down into the second level. With `PUSH_DOWN=0`, only the first level is overwritten, and a second level can be refilled only by the four-deep shift. Typical uses are a short delay line for sample streams, or two small staging stacks that share one input bus.

Top module: `mlpipe_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all four stages become 8'h00.
- R2: Operation code 2'b10 shifts the chain: A1 takes `din`, A2 takes the old A1, B1 takes the old A2 and B2 takes the old B1.
- R3: Operation code 2'b11 leaves all four stages unchanged.
- R4: Operation code 2'b00 loads A1 from `din` and leaves B1 and B2 unchanged. Operation code 2'b01 loads B1 from `din` and leaves A1 and A2 unchanged.
- R5: With `PUSH_DOWN=1`, code 2'b00 moves the old A1 into A2, and code 2'b01 moves the old B1 into B2.
- R6: With `PUSH_DOWN=0`, codes 2'b00 and 2'b01 leave the second level of the loaded pair unchanged.
- R7: With `oe_n` low, `dout` shows the stage chosen by `sel` (2'b00 A1, 2'b01 A2, 2'b10 B1, 2'b11 B2). It follows a change of `sel` without waiting for a clock.
- R8: With `oe_n` high, `dout` is high impedance, and `oe_n` has no effect on the stage contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous clear, active low |
| din | input | 8 | Shared data input |
| op | input | 2 | Operation code: 00 load A1, 01 load B1, 10 shift, 11 hold |
| sel | input | 2 | Output stage select |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 8 | Selected stage, or high impedance |

## Verification
The output path and the loading path are active in the same cycle. A stage can be selected onto `dout` while a shift or pair load is rewriting it. The output can also be disabled while the stages keep loading. The bench changes `sel` several times within one clock period, immediately after each edge, and compares every stage against a behavioural model of both variants, driven through random mixes of the operation codes. It also toggles `oe_n` in the middle of a directed run and checks that the stages are still in step afterwards.

// File: rtl/mlp_pkg.sv
`timescale 1ns/1ps
package mlp_pkg;
    typedef enum logic [1:0] {
        OP_LOAD_A = 2'b00,
        OP_LOAD_B = 2'b01,
        OP_SHIFT  = 2'b10,
        OP_HOLD   = 2'b11
    } mlp_op_e;

    localparam int unsigned NUM_STAGES = 4;
    localparam int unsigned IDX_A1 = 0;
    localparam int unsigned IDX_A2 = 1;
    localparam int unsigned IDX_B1 = 2;
    localparam int unsigned IDX_B2 = 3;
endpackage

// File: rtl/mlp_decode.sv
`timescale 1ns/1ps
module mlp_decode
    import mlp_pkg::*;
#(
    parameter bit PUSH_DOWN = 1'b1
) (
    input  logic [1:0]            op,
    output logic [NUM_STAGES-1:0] load_en,
    output logic                  b1_from_din
);
    always_comb begin
        load_en     = '0;
        b1_from_din = 1'b0;
        unique case (mlp_op_e'(op))
            OP_LOAD_A: begin
                load_en[IDX_A1] = 1'b1;
                load_en[IDX_A2] = PUSH_DOWN;
            end
            OP_LOAD_B: begin
                load_en[IDX_B1] = 1'b1;
                load_en[IDX_B2] = PUSH_DOWN;
                b1_from_din     = 1'b1;
            end
            OP_SHIFT: load_en = '1;
            default:  load_en = '0;
        endcase
    end
endmodule

// File: rtl/mlp_stages.sv
`timescale 1ns/1ps
module mlp_stages
    import mlp_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [W-1:0]                  din,
    input  logic [NUM_STAGES-1:0]         load_en,
    input  logic                          b1_from_din,
    output logic [NUM_STAGES-1:0][W-1:0]  stage_q
);
    typedef struct packed {
        logic [NUM_STAGES-1:0][W-1:0] stg;
    } stage_state_t;

    stage_state_t st_d, st_q;
    logic [NUM_STAGES-1:0][W-1:0] src;

    always_comb begin
        src[IDX_A1] = din;
        src[IDX_A2] = st_q.stg[IDX_A1];
        src[IDX_B1] = b1_from_din ? din : st_q.stg[IDX_A2];
        src[IDX_B2] = st_q.stg[IDX_B1];
        st_d = st_q;
        for (int i = 0; i < NUM_STAGES; i++) begin
            if (load_en[i]) st_d.stg[i] = src[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stage_q = st_q.stg;
endmodule

// File: rtl/mlp_outsel.sv
`timescale 1ns/1ps
module mlp_outsel
    import mlp_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [NUM_STAGES-1:0][W-1:0] stage_q,
    input  logic [1:0]                   sel,
    input  logic                         oe_n,
    output wire  [W-1:0]                 dout
);
    logic [W-1:0] pick;

    always_comb pick = stage_q[sel];

    assign dout = oe_n ? {W{1'bz}} : pick;
endmodule

// File: rtl/mlpipe_reg.sv
`timescale 1ns/1ps
module mlpipe_reg
    import mlp_pkg::*;
#(
    parameter int unsigned W         = 8,
    parameter bit          PUSH_DOWN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic [1:0]   op,
    input  logic [1:0]   sel,
    input  logic         oe_n,
    output wire  [W-1:0] dout
);
    logic [NUM_STAGES-1:0]        load_en;
    logic                         b1_from_din;
    logic [NUM_STAGES-1:0][W-1:0] stage_q;

    mlp_decode #(.PUSH_DOWN(PUSH_DOWN)) u_dec (
        .op          (op),
        .load_en     (load_en),
        .b1_from_din (b1_from_din)
    );

    mlp_stages #(.W(W)) u_stg (
        .clk         (clk),
        .rst_n       (rst_n),
        .din         (din),
        .load_en     (load_en),
        .b1_from_din (b1_from_din),
        .stage_q     (stage_q)
    );

    mlp_outsel #(.W(W)) u_out (
        .stage_q (stage_q),
        .sel     (sel),
        .oe_n    (oe_n),
        .dout    (dout)
    );
endmodule

// File: rtl/mlpipe_reg_chk.sv
`timescale 1ns/1ps
module mlpipe_reg_chk
    import mlp_pkg::*;
#(
    parameter int unsigned W         = 8,
    parameter bit          PUSH_DOWN = 1'b1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [W-1:0]                 din,
    input logic [1:0]                   op,
    input logic [1:0]                   sel,
    input logic                         oe_n,
    input logic [W-1:0]                 dout,
    input logic [NUM_STAGES-1:0][W-1:0] stage
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> stage == '0);

    a_r2_shift_chain: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_SHIFT |=> stage[IDX_A1] == $past(din)
                        && stage[IDX_A2] == $past(stage[IDX_A1])
                        && stage[IDX_B1] == $past(stage[IDX_A2])
                        && stage[IDX_B2] == $past(stage[IDX_B1]));

    a_r3_hold_all: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_HOLD |=> $stable(stage));

    a_r4_load_a: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_LOAD_A |=> stage[IDX_A1] == $past(din)
                         && $stable(stage[IDX_B1]) && $stable(stage[IDX_B2]));

    a_r4_load_b: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_LOAD_B |=> stage[IDX_B1] == $past(din)
                         && $stable(stage[IDX_A1]) && $stable(stage[IDX_A2]));

    generate
        if (PUSH_DOWN) begin : g_push
            a_r5_push_a: assert property (@(posedge clk) disable iff (!rst_n)
                op == OP_LOAD_A |=> stage[IDX_A2] == $past(stage[IDX_A1]));
            a_r5_push_b: assert property (@(posedge clk) disable iff (!rst_n)
                op == OP_LOAD_B |=> stage[IDX_B2] == $past(stage[IDX_B1]));
        end else begin : g_over
            a_r6_keep_a2: assert property (@(posedge clk) disable iff (!rst_n)
                op == OP_LOAD_A |=> $stable(stage[IDX_A2]));
            a_r6_keep_b2: assert property (@(posedge clk) disable iff (!rst_n)
                op == OP_LOAD_B |=> $stable(stage[IDX_B2]));
        end
    endgenerate

    a_r7_out_route: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> dout == stage[sel]);
endmodule

bind mlpipe_reg mlpipe_reg_chk #(.W(W), .PUSH_DOWN(PUSH_DOWN)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (din),
    .op    (op),
    .sel   (sel),
    .oe_n  (oe_n),
    .dout  (dout),
    .stage (stage_q)
);

// File: tb/tb_mlpipe_reg.sv
`timescale 1ns/1ps
module tb_mlpipe_reg;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] din;
    logic [1:0] op;
    logic [1:0] sel;
    logic       oe_n;
    tri1  [7:0] y_pd;
    tri1  [7:0] y_ow;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int m_pd[4];
    int m_ow[4];

    always #4 clk = ~clk;

    mlpipe_reg #(.W(8), .PUSH_DOWN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .din(din), .op(op),
        .sel(sel), .oe_n(oe_n), .dout(y_pd));

    mlpipe_reg #(.W(8), .PUSH_DOWN(1'b0)) dut_ow (
        .clk(clk), .rst_n(rst_n), .din(din), .op(op),
        .sel(sel), .oe_n(oe_n), .dout(y_ow));

    // behavioural model, applied at every rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            foreach (m_pd[i]) begin m_pd[i] = 0; m_ow[i] = 0; end
        end else begin
            case (op)
                2'b00: begin
                    m_pd[1] = m_pd[0]; m_pd[0] = din;
                    m_ow[0] = din;
                end
                2'b01: begin
                    m_pd[3] = m_pd[2]; m_pd[2] = din;
                    m_ow[2] = din;
                end
                2'b10: begin
                    for (int i = 3; i > 0; i--) begin
                        m_pd[i] = m_pd[i-1];
                        m_ow[i] = m_ow[i-1];
                    end
                    m_pd[0] = din; m_ow[0] = din;
                end
                default: ;
            endcase
        end
    end

    task automatic check(string tag, logic [7:0] act, int exp);
        tests++;
        if (act !== 8'(exp)) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, 8'(exp));
        end
    endtask

    // called just after a falling edge; walks sel through all stages
    task automatic compare_all(string tag);
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            #0.5;
            check({tag, " R7 pushdown"}, y_pd, m_pd[s]);
            check({tag, " R7 overwrite"}, y_ow, m_ow[s]);
        end
    endtask

    task automatic cycle(logic [1:0] o, logic [7:0] d, string tag);
        op = o; din = d;
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        rst_n = 1'b0; din = 8'h00; op = 2'b11; sel = 2'b00; oe_n = 1'b0;
        m_pd = '{default: 7}; m_ow = '{default: 7};
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        compare_all("R1 reset");
        // R8: disabled output reads as the pull-up level, enabled reads zero
        oe_n = 1'b1; #0.5;
        check("R8 hiZ pushdown", y_pd, 8'hFF);
        check("R8 hiZ overwrite", y_ow, 8'hFF);
        oe_n = 1'b0; #0.5;
        check("R8 enabled", y_pd, 8'h00);
        rst_n = 1'b1;

        cycle(2'b10, 8'h11, "R2 shift");
        cycle(2'b10, 8'h22, "R2 shift");
        cycle(2'b10, 8'h33, "R2 shift");
        cycle(2'b10, 8'h44, "R2 shift");
        cycle(2'b11, 8'hEE, "R3 hold");
        cycle(2'b00, 8'h55, "R4 R5 R6 load A");
        cycle(2'b01, 8'h66, "R4 R5 R6 load B");
        cycle(2'b00, 8'h77, "R5 R6 second load A");
        cycle(2'b11, 8'h99, "R3 hold");
        // R8: output disabled across a shift, contents keep moving
        oe_n = 1'b1;
        op = 2'b10; din = 8'hA5;
        @(posedge clk); @(negedge clk);
        #0.5;
        check("R8 hiZ during shift", y_pd, 8'hFF);
        oe_n = 1'b0;
        compare_all("R8 after disabled shift");

        for (int n = 0; n < 400; n++) begin
            if (n == 200) begin
                rst_n = 1'b0;
                cycle(2'b10, 8'h5A, "R1 mid reset");
                rst_n = 1'b1;
            end
            cycle(2'($urandom_range(0, 3)), 8'($urandom), "R2 R3 R4 R5 R6 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cycles > 5000);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule